// File: doc/BRIEF.md
# Transmit Sample FIFO with Underrun Repeat

This block buffers outgoing audio or modem samples for one output slot. A bus master or DMA engine pushes 20-bit samples in, and the frame-slot logic pops one sample per frame. When the slot asks for a sample and the buffer is empty, the block does not stall the link. It presents the last sample it delivered again, leaves its pointers alone, and latches an error flag.

Software sees the block through two 32-bit registers. The status register holds the sticky error flag, which is cleared by writing 1 to it. The control register holds the interrupt enable. The interrupt output is a registered level formed from the enable and the flag. Serial framing, codec access and the DMA engine itself lie outside this block.

Top module: `tx_underrun_fifo`

## Requirements
- R1: A pop request (`pop_i`) while `empty_o` is high sets the error flag, which reads back as bit 4 of the status register (`csr_sel_i` = 0) on the cycle after the request's clock edge.
- R2: On every underrun request, `sample_o` keeps the value it last held, until a pop finds data.
- R3: An underrun request moves neither pointer. Samples pushed afterwards come out in order, and none is skipped or repeated.
- R4: Writing a status word with bit 4 = 1 clears the flag. Writing bit 4 = 0 leaves it unchanged. If an underrun and a clearing write fall in the same cycle, the flag stays set.
- R5: Bit 4 of the status register mirrors the flag. Bit 3 of the control register (`csr_sel_i` = 1) is the interrupt enable. `irq_o` equals enable AND flag, delayed by one register stage. It is never high while the enable has been 0.
- R6: After reset, both registers read 0, `irq_o` = 0, `sample_o` = 0, `empty_o` = 1 and `full_o` = 0.
- R7: All register bits other than status bit 4 and control bit 3 read 0, whatever value was written to them.
- R8: The buffer holds 16 samples of 20 bits in first-in first-out order. `full_o` rises when 16 are stored. A push while full is dropped and does not set the error flag.
- R9: An underrun before any sample has been popped presents 0 on `sample_o`.
- R10: If a push and an underrun request fall in the same cycle, the request counts as an underrun. The pushed sample is then delivered by the next pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Write a sample into the buffer |
| push_data_i | input | 20 | Sample to write |
| full_o | output | 1 | Buffer holds 16 samples |
| empty_o | output | 1 | Buffer holds no samples |
| pop_i | input | 1 | Slot requests the next sample |
| sample_o | output | 20 | Sample delivered to the slot (registered) |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 1 | Register select: 0 status, 1 control |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Read data for the selected register |
| irq_o | output | 1 | Registered interrupt level |

## Verification
The assertions assume that `push_i` and `pop_i` are known (0 or 1) in every cycle after reset. They also assume that a register write lasts a single cycle and that `csr_sel_i` is valid whenever `csr_we_i` is high. The bench drives every input at the falling edge, holds each write for exactly one cycle, and returns all strobes to 0 between operations. Pops on an empty buffer, pushes into a full buffer, pushes that coincide with underruns, and clears that coincide with underruns are all produced on purpose, so every guarded condition is reached.

// File: rtl/txu_pkg.sv
package txu_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned ERR_BIT = 4;
  localparam int unsigned IE_BIT  = 3;
  typedef enum logic {SEL_STATUS = 1'b0, SEL_CTRL = 1'b1} csr_sel_e;
endpackage

// File: rtl/txu_fifo.sv
module txu_fifo #(
  parameter int unsigned DW    = 20,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic          full_o,
  output logic          empty_o,
  output logic          underrun_o,
  output logic [DW-1:0] sample_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW:0]   wr_q, rd_q;
  logic [DW-1:0] last_q;
  logic          push_ok, pop_ok;

  assign empty_o    = (wr_q == rd_q);
  assign full_o     = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign push_ok    = push_i && !full_o;
  assign pop_ok     = pop_i && !empty_o;
  assign underrun_o = pop_i && empty_o;
  assign sample_o   = last_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q[AW-1:0]] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      last_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + 1'b1;
      if (pop_ok) begin
        rd_q   <= rd_q + 1'b1;
        last_q <= mem_q[rd_q[AW-1:0]];
      end
    end
  end

  initial assert (DEPTH == (1 << AW)) else $error("DEPTH must be a power of two");

  assert_hold_on_underrun_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> $stable(sample_o));
  assert_rd_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> $stable(rd_q));
  assert_wr_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !push_i) |=> $stable(wr_q));
  assert_drop_when_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> $stable(wr_q) && full_o);
endmodule

// File: rtl/txu_err.sv
module txu_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic underrun_i,
  input  logic clr_i,
  input  logic ie_wr_i,
  input  logic ie_d_i,
  output logic err_o,
  output logic ie_o,
  output logic irq_o
);
  logic err_q, ie_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      ie_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      // set has priority over a same-cycle clear
      if (underrun_i)  err_q <= 1'b1;
      else if (clr_i)  err_q <= 1'b0;
      if (ie_wr_i)     ie_q  <= ie_d_i;
      irq_q <= ie_q & err_q;
    end
  end

  assign err_o = err_q;
  assign ie_o  = ie_q;
  assign irq_o = irq_q;

  assert_flag_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_i |=> err_q);
  assert_flag_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr_i) |=> err_q);
  assert_irq_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_q |=> !irq_q);
endmodule

// File: rtl/txu_csr.sv
module txu_csr
  import txu_pkg::*;
(
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             err_i,
  input  logic             ie_i,
  output logic             clr_o,
  output logic             ie_wr_o,
  output logic             ie_d_o,
  output logic [REG_W-1:0] rdata_o
);
  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[REG_W-1:ERR_BIT+1], wdata_i[IE_BIT-1:0]};

  assign clr_o   = we_i && (sel_i == SEL_STATUS) && wdata_i[ERR_BIT];
  assign ie_wr_o = we_i && (sel_i == SEL_CTRL);
  assign ie_d_o  = wdata_i[IE_BIT];

  always_comb begin
    rdata_o = '0;
    if (sel_i == SEL_CTRL) rdata_o[IE_BIT]  = ie_i;
    else                   rdata_o[ERR_BIT] = err_i;
  end
endmodule

// File: rtl/tx_underrun_fifo.sv
module tx_underrun_fifo
  import txu_pkg::*;
#(
  parameter int unsigned DW    = 20,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [DW-1:0]    push_data_i,
  output logic             full_o,
  output logic             empty_o,
  input  logic             pop_i,
  output logic [DW-1:0]    sample_o,
  input  logic             csr_we_i,
  input  logic             csr_sel_i,
  input  logic [REG_W-1:0] csr_wdata_i,
  output logic [REG_W-1:0] csr_rdata_o,
  output logic             irq_o
);
  logic underrun, clr, ie_wr, ie_d, err, ie;

  txu_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i, .data_i(push_data_i), .pop_i,
    .full_o, .empty_o, .underrun_o(underrun), .sample_o
  );

  txu_csr u_csr (
    .we_i(csr_we_i), .sel_i(csr_sel_i), .wdata_i(csr_wdata_i),
    .err_i(err), .ie_i(ie), .clr_o(clr), .ie_wr_o(ie_wr), .ie_d_o(ie_d),
    .rdata_o(csr_rdata_o)
  );

  txu_err u_err (
    .clk_i, .rst_ni, .underrun_i(underrun), .clr_i(clr),
    .ie_wr_i(ie_wr), .ie_d_i(ie_d), .err_o(err), .ie_o(ie), .irq_o
  );
endmodule

// File: tb/tx_underrun_fifo_tb.sv
module tx_underrun_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        push = 0, pop = 0, we = 0, sel = 0;
  logic [19:0] pdata = '0;
  logic [31:0] wdata = '0;
  logic        full, empty, irq;
  logic [19:0] sample;
  logic [31:0] rdata;

  int total = 0, bad = 0;

  logic [19:0] q_m[$];
  logic [19:0] last_m = '0;
  logic        err_m = 0, ie_m = 0, irq_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_underrun_fifo u_dut (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_data_i(pdata),
    .full_o(full), .empty_o(empty), .pop_i(pop), .sample_o(sample),
    .csr_we_i(we), .csr_sel_i(sel), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "sample_o", 32'(sample), 32'(last_m));
    chk(tag, "empty_o", 32'(empty), 32'(q_m.size() == 0));
    chk(tag, "full_o", 32'(full), 32'(q_m.size() == DEPTH));
    chk(tag, "irq_o", 32'(irq), 32'(irq_m));
  endtask

  task automatic step(input string tag, input logic p, input logic [19:0] d, input logic r,
                      input logic w, input logic s, input logic [31:0] wd);
    int sz;
    logic irq_n;
    push = p; pdata = d; pop = r; we = w; sel = s; wdata = wd;
    @(posedge clk);
    sz = q_m.size();
    irq_n = ie_m & err_m;
    if (r && sz == 0) err_m = 1;
    else if (w && !s && wd[4]) err_m = 0;
    if (w && s) ie_m = wd[3];
    if (r && sz > 0) last_m = q_m.pop_front();
    if (p && sz < DEPTH) q_m.push_back(d);
    irq_m = irq_n;
    @(negedge clk);
    push = 0; pop = 0; we = 0;
    compare(tag);
  endtask

  task automatic rd_chk(input string tag, input logic s, input logic [31:0] exp);
    sel = s;
    #1;
    chk(tag, s ? "ctrl read" : "status read", rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R6");
    rd_chk("R6", 0, 32'h0);
    rd_chk("R6", 1, 32'h0);

    // underrun before any data
    step("R9", 0, 0, 1, 0, 0, 0);
    rd_chk("R1", 0, 32'h10);
    step("R9", 0, 0, 1, 0, 0, 0);

    // write-0 keeps, write-1 clears
    step("R4", 0, 0, 0, 1, 0, 32'hFFFF_FFEF);
    rd_chk("R4", 0, 32'h10);
    step("R4", 0, 0, 0, 1, 0, 32'h10);
    rd_chk("R4", 0, 32'h0);

    // ordering then repeat on underrun
    for (int i = 0; i < 3; i++) step("R8", 1, 20'hA0000 + 20'(i), 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R8", 0, 0, 1, 0, 0, 0);
    step("R2", 0, 0, 1, 0, 0, 0);
    step("R2", 0, 0, 1, 0, 0, 0);
    rd_chk("R1", 0, 32'h10);

    // interrupt gating
    step("R5", 0, 0, 0, 0, 0, 0);
    chk("R5", "irq with enable off", 32'(irq), 32'h0);
    step("R5", 0, 0, 0, 1, 1, 32'hFFFF_FFFF);
    rd_chk("R7", 1, 32'h8);
    step("R5", 0, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0);
    chk("R5", "irq enabled", 32'(irq), 32'h1);
    step("R5", 0, 0, 0, 1, 0, 32'h10);
    step("R5", 0, 0, 0, 0, 0, 0);
    chk("R5", "irq after clear", 32'(irq), 32'h0);

    // fill past full
    for (int i = 0; i < DEPTH + 2; i++) step("R8", 1, 20'h50000 + 20'(i), 0, 0, 0, 0);
    chk("R8", "full", 32'(full), 32'h1);
    rd_chk("R8", 0, 32'h0);
    step("R8", 1, 20'h7FFFF, 1, 0, 0, 0);
    for (int i = 0; i < DEPTH - 1; i++) step("R3", 0, 0, 1, 0, 0, 0);
    chk("R8", "drained", 32'(empty), 32'h1);

    // push coinciding with underrun
    step("R10", 1, 20'hCAFE1, 1, 0, 0, 0);
    rd_chk("R10", 0, 32'h10);
    step("R10", 0, 0, 1, 0, 0, 0);
    step("R3", 1, 20'h12345, 0, 0, 0, 0);
    step("R3", 1, 20'h23456, 0, 0, 0, 0);
    step("R3", 0, 0, 1, 0, 0, 0);
    step("R3", 0, 0, 1, 0, 0, 0);

    // set beats clear in the same cycle
    step("R4", 0, 0, 1, 1, 0, 32'hFFFF_FFFF);
    rd_chk("R4", 0, 32'h10);
    step("R7", 0, 0, 0, 1, 1, 32'hFFFF_FFF7);
    rd_chk("R7", 1, 32'h0);
    rd_chk("R7", 0, 32'h10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule